// File: doc/BRIEF.md
# SDRAM Bank Row Timing Tracker

This block watches the command stream sent to a four-bank SDRAM and keeps, for every bank, a record of whether a row is open and how many cycles have passed since it was opened. From that record it tells the command scheduler, one flag per bank, when a column read or write may be sent, when the bank may be closed, and when it may be opened. A single counter shared by all banks spaces row openings so that the supply can recover after one bank senses a row before the next bank senses one.

The timing limits are cycle counts set at elaboration. A designer finds each count by dividing the minimum time by the clock period and rounding up to the next whole number. The block also raises a per-bank warning once a row has stayed open for the maximum allowed time. A command that breaks a timing rule does not change any bank state, and it sets a violation pulse on the next cycle.

Top module: `bank_timing_tracker`

## Requirements
- R1: After reset every bank is idle: `act_ready` is all ones, and `rw_ready`, `pre_ready`, `max_warn` and `violation` are all zero.
- R2: A valid activate (`cmd_op` = 0) to a bank whose `act_ready` bit is set opens that bank. From the next cycle its `act_ready` bit is low and stays low until the bank is closed.
- R3: A bank's `rw_ready` bit rises exactly T_RCD cycles after the cycle of its accepted activate. A read (`cmd_op` = 1) or write (`cmd_op` = 2) to a bank whose `rw_ready` is set raises no violation.
- R4: After an accepted activate, `act_ready` is low for every bank for the next T_RRD-1 cycles. Idle banks show it high again T_RRD cycles after the activate.
- R5: A bank's `pre_ready` bit rises exactly T_RAS_MIN cycles after its accepted activate. A valid precharge (`cmd_op` = 3) while `pre_ready` is set returns the bank to idle on the next cycle, with `rw_ready`, `pre_ready` and `max_warn` low.
- R6: A bank's `max_warn` bit rises exactly T_RAS_MAX cycles after its accepted activate and stays high until the bank is precharged.
- R7: The command sets `violation` high for one cycle, on the cycle after the command, and leaves every bank's state and row-open time unchanged, in these cases: an activate to an open bank, an activate inside the spacing window, a read or write to a bank whose `rw_ready` is low, or a precharge to an open bank before `pre_ready`.
- R8: A precharge to an idle bank is ignored: there is no violation and the bank stays idle.
- R9: While `cmd_valid` is low, `violation` stays low on the next cycle whatever `cmd_op` and `cmd_bank` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 activate, 1 read, 2 write, 3 precharge |
| cmd_bank | input | BANK_W (2) | Target bank |
| act_ready | output | NUM_BANKS (4) | Bank may be activated |
| rw_ready | output | NUM_BANKS (4) | Bank may take a read or write |
| pre_ready | output | NUM_BANKS (4) | Bank may be precharged |
| max_warn | output | NUM_BANKS (4) | Row open for the maximum allowed time |
| violation | output | 1 | Previous command broke a timing rule |

## Verification
Every result is registered. The `violation` pulse and the state change caused by a command therefore appear one cycle after the command's edge. The flag `act_ready` of the other banks returns T_RRD cycles after an activate, `rw_ready` rises T_RCD cycles after it, `pre_ready` T_RAS_MIN cycles after it and `max_warn` T_RAS_MAX cycles after it. The bench drives each command for one cycle on a falling edge and then samples on every following falling edge. It keeps a count k of cycles since the activate and compares each flag with a threshold on k. This sweep runs on every bank in turn, so the cycle in which each result is due is checked directly.

// File: rtl/bank_timing_pkg.sv
package bank_timing_pkg;
    typedef enum logic [1:0] {
        OP_ACT   = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_PRE   = 2'd3
    } cmd_op_e;
endpackage

// File: rtl/bank_row_timer.sv
module bank_row_timer #(
    parameter int T_RCD     = 3,
    parameter int T_RAS_MIN = 7,
    parameter int T_RAS_MAX = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic open_i,
    input  logic close_i,
    output logic active_o,
    output logic rw_ok_o,
    output logic pre_ok_o,
    output logic max_hit_o
);
    localparam int CNT_W = $clog2(T_RAS_MAX + 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] age;
    } row_state_t;

    row_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (open_i) begin
            st_d.active = 1'b1;
            st_d.age    = CNT_W'(1);
        end else if (close_i) begin
            st_d.active = 1'b0;
            st_d.age    = '0;
        end else if (st_q.active && (st_q.age != CNT_W'(T_RAS_MAX))) begin
            st_d.age = st_q.age + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o  = st_q.active;
    assign rw_ok_o   = st_q.active && (st_q.age >= CNT_W'(T_RCD));
    assign pre_ok_o  = st_q.active && (st_q.age >= CNT_W'(T_RAS_MIN));
    assign max_hit_o = st_q.active && (st_q.age == CNT_W'(T_RAS_MAX));
endmodule

// File: rtl/act_spacing_timer.sv
module act_spacing_timer #(
    parameter int T_RRD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic clear_o
);
    localparam int GAP_W = $clog2(T_RRD + 1);

    logic [GAP_W-1:0] gap_d, gap_q;

    always_comb begin
        gap_d = gap_q;
        if (fire_i)              gap_d = GAP_W'(T_RRD - 1);
        else if (gap_q != '0)    gap_d = gap_q - GAP_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gap_q <= '0;
        else        gap_q <= gap_d;
    end

    assign clear_o = (gap_q == '0);
endmodule

// File: rtl/cmd_judge.sv
module cmd_judge
    import bank_timing_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                 cmd_valid,
    input  cmd_op_e              op,
    input  logic [BANK_W-1:0]    bank,
    input  logic [NUM_BANKS-1:0] active,
    input  logic [NUM_BANKS-1:0] rw_ok,
    input  logic [NUM_BANKS-1:0] pre_ok,
    input  logic                 spacing_clear,
    output logic [NUM_BANKS-1:0] open_o,
    output logic [NUM_BANKS-1:0] close_o,
    output logic                 bad_o
);
    logic [NUM_BANKS-1:0] sel;

    assign sel = NUM_BANKS'(1) << bank;

    always_comb begin
        open_o  = '0;
        close_o = '0;
        bad_o   = 1'b0;
        if (cmd_valid) begin
            unique case (op)
                OP_ACT: begin
                    if (((active & sel) == '0) && spacing_clear) open_o = sel;
                    else                                         bad_o  = 1'b1;
                end
                OP_READ, OP_WRITE: begin
                    if ((rw_ok & sel) == '0) bad_o = 1'b1;
                end
                OP_PRE: begin
                    if ((pre_ok & sel) != '0)      close_o = sel;
                    else if ((active & sel) != '0) bad_o   = 1'b1;
                end
                default: bad_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/bank_timing_tracker.sv
module bank_timing_tracker
    import bank_timing_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RCD     = 3,
    parameter int T_RRD     = 2,
    parameter int T_RAS_MIN = 7,
    parameter int T_RAS_MAX = 10000,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [BANK_W-1:0]    cmd_bank,
    output logic [NUM_BANKS-1:0] act_ready,
    output logic [NUM_BANKS-1:0] rw_ready,
    output logic [NUM_BANKS-1:0] pre_ready,
    output logic [NUM_BANKS-1:0] max_warn,
    output logic                 violation
);
    logic [NUM_BANKS-1:0] active, open_v, close_v;
    logic                 spacing_clear, bad;
    logic                 viol_d, viol_q;

    cmd_judge #(.NUM_BANKS(NUM_BANKS)) i_judge (
        .cmd_valid     (cmd_valid),
        .op            (cmd_op_e'(cmd_op)),
        .bank          (cmd_bank),
        .active        (active),
        .rw_ok         (rw_ready),
        .pre_ok        (pre_ready),
        .spacing_clear (spacing_clear),
        .open_o        (open_v),
        .close_o       (close_v),
        .bad_o         (bad)
    );

    act_spacing_timer #(.T_RRD(T_RRD)) i_spacing (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (|open_v),
        .clear_o (spacing_clear)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_row_timer #(
            .T_RCD     (T_RCD),
            .T_RAS_MIN (T_RAS_MIN),
            .T_RAS_MAX (T_RAS_MAX)
        ) i_row (
            .clk       (clk),
            .rst_n     (rst_n),
            .open_i    (open_v[b]),
            .close_i   (close_v[b]),
            .active_o  (active[b]),
            .rw_ok_o   (rw_ready[b]),
            .pre_ok_o  (pre_ready[b]),
            .max_hit_o (max_warn[b])
        );
    end

    always_comb viol_d = bad;

    always_ff @(posedge clk) begin
        if (!rst_n) viol_q <= 1'b0;
        else        viol_q <= viol_d;
    end

    assign act_ready = ~active & {NUM_BANKS{spacing_clear}};
    assign violation = viol_q;
endmodule

// File: rtl/bank_timing_checker.sv
module bank_timing_checker
    import bank_timing_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RRD     = 2,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic [1:0]           cmd_op,
    input logic [BANK_W-1:0]    cmd_bank,
    input logic [NUM_BANKS-1:0] act_ready,
    input logic [NUM_BANKS-1:0] rw_ready,
    input logic [NUM_BANKS-1:0] pre_ready,
    input logic [NUM_BANKS-1:0] max_warn,
    input logic                 violation
);
    p_open_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (act_ready & (rw_ready | pre_ready | max_warn)) == '0);

    p_read_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OP_READ || cmd_op == OP_WRITE) && !rw_ready[cmd_bank])
        |=> violation);

    p_read_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OP_READ || cmd_op == OP_WRITE) && rw_ready[cmd_bank])
        |=> !violation);

    p_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_PRE && pre_ready[cmd_bank])
        |=> (!violation && !rw_ready[$past(cmd_bank)] && !pre_ready[$past(cmd_bank)]));

    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !violation);

    p_act_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ACT && act_ready[cmd_bank]) |=> !violation);

    if (T_RRD > 1) begin : g_gap
        p_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && cmd_op == OP_ACT && act_ready[cmd_bank]) |=> (act_ready == '0));
    end
endmodule

bind bank_timing_tracker bank_timing_checker #(
    .NUM_BANKS (NUM_BANKS),
    .T_RRD     (T_RRD)
) i_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_bank  (cmd_bank),
    .act_ready (act_ready),
    .rw_ready  (rw_ready),
    .pre_ready (pre_ready),
    .max_warn  (max_warn),
    .violation (violation)
);

// File: tb/test_bank_timing_tracker.sv
module test_bank_timing_tracker;
    localparam int NB   = 4;
    localparam int RCD  = 3;
    localparam int RRD  = 2;
    localparam int RMIN = 7;
    localparam int RMAX = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [1:0]    cmd_bank = 2'd0;
    logic [NB-1:0] act_ready, rw_ready, pre_ready, max_warn;
    logic          violation;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bank_timing_tracker #(
        .NUM_BANKS (NB), .T_RCD (RCD), .T_RRD (RRD),
        .T_RAS_MIN (RMIN), .T_RAS_MAX (RMAX)
    ) i_bank_timing_tracker (
        .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
        .cmd_bank (cmd_bank), .act_ready (act_ready), .rw_ready (rw_ready),
        .pre_ready (pre_ready), .max_warn (max_warn), .violation (violation)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // caller stands on a falling edge; returns one cycle later on a falling edge
    task automatic issue(input logic [1:0] op, input logic [1:0] bank);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_bank  = bank;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 act_ready", int'(act_ready), 15);
        check("R1 rw_ready", int'(rw_ready), 0);
        check("R1 pre_ready", int'(pre_ready), 0);
        check("R1 max_warn", int'(max_warn), 0);
        check("R1 violation", int'(violation), 0);

        // sweep every bank through its whole row-open window
        for (int b = 0; b < NB; b++) begin
            issue(2'd0, 2'(b));
            for (int k = 1; k <= RMAX + 1; k++) begin
                check("R3 rw_ready", int'(rw_ready[b]), int'(k >= RCD));
                check("R5 pre_ready", int'(pre_ready[b]), int'(k >= RMIN));
                check("R6 max_warn", int'(max_warn[b]), int'(k >= RMAX));
                check("R2 act_ready own", int'(act_ready[b]), 0);
                check("R4 act_ready other", int'(act_ready[(b + 1) % NB]), int'(k >= RRD));
                if (k == 1) check("R2 no violation", int'(violation), 0);
                @(negedge clk);
            end
            issue(2'd3, 2'(b));
            check("R5 closed act_ready", int'(act_ready), 15);
            check("R5 closed rw_ready", int'(rw_ready), 0);
            check("R5 closed pre_ready", int'(pre_ready), 0);
            check("R6 warn cleared", int'(max_warn), 0);
            check("R5 violation", int'(violation), 0);
        end

        // R4 activates at exactly the spacing distance
        issue(2'd0, 2'd1);
        @(negedge clk);
        issue(2'd0, 2'd2);
        check("R4 spaced act violation", int'(violation), 0);
        check("R4 window act_ready", int'(act_ready), 0);
        @(negedge clk);
        check("R4 after window act_ready", int'(act_ready), 9);
        repeat (RMIN) @(negedge clk);
        issue(2'd3, 2'd1);
        issue(2'd3, 2'd2);
        check("R5 both closed", int'(act_ready), 15);

        // R7 rule breaks, k counts cycles since activate of bank 0
        issue(2'd0, 2'd0);                  // k=1
        issue(2'd0, 2'd1);                  // k=2, inside spacing
        check("R7 act in window", int'(violation), 1);
        check("R7 bank1 unchanged", int'(act_ready[1]), 1);
        issue(2'd1, 2'd0);                  // k=3, read too early
        check("R7 early read", int'(violation), 1);
        check("R3 rw_ready at k3", int'(rw_ready[0]), 1);
        issue(2'd3, 2'd0);                  // k=4, early precharge
        check("R7 early pre", int'(violation), 1);
        check("R7 bank0 still open", int'(rw_ready[0]), 1);
        issue(2'd0, 2'd0);                  // k=5, act to open bank
        check("R7 act open bank", int'(violation), 1);
        @(negedge clk);                     // k=6
        check("R7 pulse one cycle", int'(violation), 0);
        check("R7 age kept k6", int'(pre_ready[0]), 0);
        @(negedge clk);                     // k=7
        check("R7 age kept k7", int'(pre_ready[0]), 1);
        issue(2'd2, 2'd2);                  // write to idle bank
        check("R7 write idle", int'(violation), 1);
        check("R7 bank2 idle", int'(act_ready[2]), 1);
        issue(2'd3, 2'd3);                  // precharge idle bank
        check("R8 pre idle violation", int'(violation), 0);
        check("R8 bank3 idle", int'(act_ready[3]), 1);
        cmd_op = 2'd1; cmd_bank = 2'd3;
        @(negedge clk);
        check("R9 invalid cmd", int'(violation), 0);
        issue(2'd2, 2'd0);
        check("R3 legal write", int'(violation), 0);
        issue(2'd3, 2'd0);
        check("R5 final close", int'(act_ready), 15);
        check("R5 final violation", int'(violation), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule